// File: doc/BRIEF.md
# Breakpoint Address Comparator Bank

This block holds a bank of programmable break addresses and compares each against the CPU address bus. When an enabled entry matches a bus cycle that falls inside the ROM region, it raises a non-maskable interrupt request. The request lasts one clock. Software uses it to trap execution at chosen ROM locations, for example to patch or trace code that cannot be rewritten.

The CPU programs the bank with ordinary byte writes into a 256-byte register window at the top of the 24-bit address map, and reads the same bytes back there. Each entry takes four consecutive bytes: three address bytes, then an enable byte. Every stored bit sits at the same position as the address bit it matches, so software writes address bytes with no shifting. One more register, just past the last entry, holds a global enable that gates every request.

Top module: `brk_cmp_bank`

## Requirements
- R1: While `rstN` is low, and after reset until software writes, all entry enables and the global enable are 0, every window byte reads 0x00, and `irqReq` is low.
- R2: A write is a cycle with `busStrobe`=1, `busWrite`=1 and `busAddr[23:8]`=0xFFFF. The register offset is `busAddr[7:0]`. For offset 4*n+k, with n from 0 to 31, lane k=0 stores A19..A16 in data bits 3:0 (bits 7:4 read back 0). Lane k=1 stores A15..A8 in bits 7:0. Lane k=2 stores A7..A2 in bits 7:2 (bits 1:0 read back 0). Lane k=3 stores the entry enable in bit 7 (1 enables), and its other bits read back 0.
- R3: `rdData` is combinational. During a cycle with `busStrobe`=1, `busWrite`=0 and an address inside the window, it shows the stored byte for that offset. In every other case it is 0x00. Offsets 0x81 to 0xFF read 0x00 and ignore writes.
- R4: An entry matches when its enable is 1 and address bits 19..2 of `busAddr` equal its stored bits. Address bits 23..20 and 1..0 are ignored.
- R5: `irqReq` goes high for exactly one clock, in the cycle after the first clock edge at which `busStrobe`, `romSel` and some entry match are all true. It does not fire again until `busStrobe` has been low for at least one edge.
- R6: The global enable is bit 0 of offset 0x80 and reads back as {7'b0, enable}. While it is 0, no request is produced.
- R7: No request is produced while `romSel` is low, and no request is produced for a matching address whose entry enable is 0.
- R8: Entries are independent: a match on any enabled entry, including entry 0 and entry 31, raises the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 24 | CPU address bus |
| busStrobe | input | 1 | Bus cycle in progress |
| busWrite | input | 1 | 1 for a write cycle, 0 for a read cycle |
| romSel | input | 1 | ROM chip-select for the 1MB ROM region |
| wrData | input | 8 | Write data byte |
| rdData | output | 8 | Register readback byte |
| irqReq | output | 1 | Registered one-clock interrupt request |

## Verification
A table of probe addresses is run against a bank that holds several programmed entries:
- An exact hit checks that the comparator works at all.
- Hits that differ only in bits 1..0, or only above bit 19, show that those bits are ignored.
- Neighbouring 4-byte groups, and an address that differs in a single bit of 19..16, show that every compared bit counts.
- Probes with `romSel` low, or at a disabled entry, separate the match from its qualifiers.

Each probe also holds the strobe for a second clock, to tell a one-clock pulse from a level. Directed tests then cover:
- the pad bits on readback;
- the unimplemented offsets;
- clearing the global enable;
- a reset in the middle of the run.

// File: rtl/brk_cmp_pkg.sv
package brk_cmp_pkg;
  // Strobes from the decoder to the storage/compare datapath.
  typedef struct packed {
    logic entryWr;   // write to an entry lane
    logic globalWr;  // write to the global enable
    logic entryRd;   // read of an entry lane
    logic globalRd;  // read of the global enable
  } ctlStrobes_t;
endpackage

// File: rtl/brk_cmp_ctrl.sv
module brk_cmp_ctrl
  import brk_cmp_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int NUM_ENTRIES = 32,
  parameter logic [ADDR_W-9:0] WIN_TAG = '1
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [ADDR_W-1:0]              busAddr,
  input  logic                           busStrobe,
  input  logic                           busWrite,
  input  logic                           romSel,
  input  logic                           matchAny,
  input  logic                           globalEn,
  output ctlStrobes_t                    strobes,
  output logic [$clog2(NUM_ENTRIES)-1:0] regIdx,
  output logic [1:0]                     regLane,
  output logic                           irqReq
);
  localparam int IDX_W = $clog2(NUM_ENTRIES);
  localparam logic [8:0] GLOBAL_OFF = 9'(NUM_ENTRIES * 4);

  logic       inWindow;
  logic [7:0] offset;
  logic       entryHit;
  logic       globalHit;
  logic       qualHit;
  logic       firedQ;

  assign offset    = busAddr[7:0];
  assign inWindow  = (busAddr[ADDR_W-1:8] == WIN_TAG);
  assign entryHit  = inWindow && ({1'b0, offset} < GLOBAL_OFF);
  assign globalHit = inWindow && ({1'b0, offset} == GLOBAL_OFF);
  assign regIdx    = offset[IDX_W+1:2];
  assign regLane   = offset[1:0];

  always_comb begin
    strobes.entryWr  = busStrobe && busWrite && entryHit;
    strobes.globalWr = busStrobe && busWrite && globalHit;
    strobes.entryRd  = busStrobe && !busWrite && entryHit;
    strobes.globalRd = busStrobe && !busWrite && globalHit;
  end

  // One pulse per bus cycle: firedQ remembers a request until the strobe drops.
  assign qualHit = busStrobe && romSel && matchAny;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      firedQ <= 1'b0;
      irqReq <= 1'b0;
    end else begin
      irqReq <= qualHit && !firedQ;
      firedQ <= busStrobe && (firedQ || qualHit);
    end
  end

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |=> !irqReq);
  a_r7_rom_qualified: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> $past(busStrobe && romSel));
  a_r6_global_gate: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> $past(globalEn));
endmodule

// File: rtl/brk_cmp_dpath.sv
module brk_cmp_dpath
  import brk_cmp_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int NUM_ENTRIES = 32,
  parameter int REGION_MSB  = 19,
  parameter int IGNORE_LSB  = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [ADDR_W-1:0]              busAddr,
  input  logic [7:0]                     wrData,
  input  ctlStrobes_t                    strobes,
  input  logic [$clog2(NUM_ENTRIES)-1:0] regIdx,
  input  logic [1:0]                     regLane,
  output logic [7:0]                     rdData,
  output logic                           matchAny,
  output logic                           globalEn
);
  localparam logic [ADDR_W-1:0] KEEP_MASK = ADDR_W'(
    ((64'd1 << (REGION_MSB + 1)) - 64'd1) & ~((64'd1 << IGNORE_LSB) - 64'd1));
  localparam logic [7:0] MASK_HI  = KEEP_MASK[ADDR_W-1 -: 8];
  localparam logic [7:0] MASK_MID = KEEP_MASK[ADDR_W-9 -: 8];
  localparam logic [7:0] MASK_LO  = KEEP_MASK[7:0];

  logic [ADDR_W-1:0]      entryAddr [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] entryEn;
  logic [NUM_ENTRIES-1:0] hitVec;
  logic                   globalEnQ;

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
    logic sel;
    assign sel = strobes.entryWr && (regIdx == i);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        entryAddr[i] <= '0;
        entryEn[i]   <= 1'b0;
      end else if (sel) begin
        case (regLane)
          2'd0:    entryAddr[i][ADDR_W-1 -: 8] <= wrData & MASK_HI;
          2'd1:    entryAddr[i][ADDR_W-9 -: 8] <= wrData & MASK_MID;
          2'd2:    entryAddr[i][7:0]           <= wrData & MASK_LO;
          default: entryEn[i]                  <= wrData[7];
        endcase
      end
    end

    assign hitVec[i] = entryEn[i] && (((entryAddr[i] ^ busAddr) & KEEP_MASK) == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 globalEnQ <= 1'b0;
    else if (strobes.globalWr) globalEnQ <= wrData[0];
  end

  assign globalEn = globalEnQ;
  assign matchAny = globalEnQ && (|hitVec);

  always_comb begin
    rdData = 8'h00;
    if (strobes.entryRd) begin
      case (regLane)
        2'd0:    rdData = entryAddr[regIdx][ADDR_W-1 -: 8];
        2'd1:    rdData = entryAddr[regIdx][ADDR_W-9 -: 8];
        2'd2:    rdData = entryAddr[regIdx][7:0];
        default: rdData = {entryEn[regIdx], 7'b0};
      endcase
    end else if (strobes.globalRd) begin
      rdData = {7'b0, globalEnQ};
    end
  end

  a_r2_enable_lands: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.entryWr && regLane == 2'd3) |=> entryEn[$past(regIdx)] == $past(wrData[7]));
  a_r6_cleared_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.globalWr && !wrData[0]) |=> !matchAny);
endmodule

// File: rtl/brk_cmp_bank.sv
module brk_cmp_bank
  import brk_cmp_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int NUM_ENTRIES = 32,
  parameter int REGION_MSB  = 19,
  parameter int IGNORE_LSB  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busStrobe,
  input  logic              busWrite,
  input  logic              romSel,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic              irqReq
);
  localparam int IDX_W = $clog2(NUM_ENTRIES);

  ctlStrobes_t      strobes;
  logic [IDX_W-1:0] regIdx;
  logic [1:0]       regLane;
  logic             matchAny;
  logic             globalEn;

  brk_cmp_ctrl #(
    .ADDR_W(ADDR_W), .NUM_ENTRIES(NUM_ENTRIES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busStrobe(busStrobe),
    .busWrite(busWrite), .romSel(romSel), .matchAny(matchAny),
    .globalEn(globalEn), .strobes(strobes), .regIdx(regIdx),
    .regLane(regLane), .irqReq(irqReq)
  );

  brk_cmp_dpath #(
    .ADDR_W(ADDR_W), .NUM_ENTRIES(NUM_ENTRIES),
    .REGION_MSB(REGION_MSB), .IGNORE_LSB(IGNORE_LSB)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .wrData(wrData),
    .strobes(strobes), .regIdx(regIdx), .regLane(regLane),
    .rdData(rdData), .matchAny(matchAny), .globalEn(globalEn)
  );
endmodule

// File: tb/brk_cmp_bank_bench.sv
module brk_cmp_bank_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] busAddr = '0;
  logic        busStrobe = 1'b0;
  logic        busWrite = 1'b0;
  logic        romSel = 1'b0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic        irqReq;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  brk_cmp_bank u_brk_cmp_bank (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busStrobe(busStrobe),
    .busWrite(busWrite), .romSel(romSel), .wrData(wrData),
    .rdData(rdData), .irqReq(irqReq)
  );

  // {probe address, romSel, expected request}
  localparam int NV = 11;
  localparam logic [25:0] VEC [NV] = '{
    {24'h012344, 1'b1, 1'b1},  // R4 exact hit entry 0
    {24'h012347, 1'b1, 1'b1},  // R4 bits 1..0 ignored
    {24'hA12345, 1'b1, 1'b1},  // R4 bits 23..20 ignored
    {24'h012348, 1'b1, 1'b0},  // R4 next 4-byte group
    {24'h012344, 1'b0, 1'b0},  // R7 romSel low
    {24'h0ABCD8, 1'b1, 1'b0},  // R7 disabled entry 5
    {24'h0FFFFC, 1'b1, 1'b1},  // R8 entry 31
    {24'h050000, 1'b1, 1'b1},  // R8 entry 7
    {24'h050004, 1'b1, 1'b0},  // R4 miss
    {24'h112344, 1'b1, 1'b1},  // R4 bit 20 ignored
    {24'h002344, 1'b1, 1'b0}   // R4 bit 16 compared
  };

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic busWr(input logic [23:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; wrData = d; busWrite = 1'b1; busStrobe = 1'b1; romSel = 1'b0;
    @(negedge clk);
    busStrobe = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [23:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrite = 1'b0; busStrobe = 1'b1; romSel = 1'b0;
    #1 d = rdData;
    @(negedge clk);
    busStrobe = 1'b0;
  endtask

  // Hold one bus cycle for two clocks: pulse expected after the first edge only.
  task automatic probe(input string req, input logic [23:0] a, input logic rs, input logic exp);
    @(negedge clk);
    busAddr = a; romSel = rs; busWrite = 1'b0; busStrobe = 1'b1;
    @(negedge clk);
    chk(req, {7'b0, irqReq}, {7'b0, exp});
    @(negedge clk);
    chk("R5 single pulse", {7'b0, irqReq}, 8'h00);
    busStrobe = 1'b0; romSel = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", {7'b0, irqReq}, 8'h00);
    rstN = 1'b1;
    busRd(24'hFFFF03, d); chk("R1 entry enable after reset", d, 8'h00);
    busRd(24'hFFFF80, d); chk("R1 global after reset", d, 8'h00);
    busRd(24'hFFFF7D, d); chk("R1 entry byte after reset", d, 8'h00);

    // R2 lane layout and pad bits
    busWr(24'hFFFF08, 8'hFF); busRd(24'hFFFF08, d); chk("R2 lane0 pad", d, 8'h0F);
    busWr(24'hFFFF09, 8'hA5); busRd(24'hFFFF09, d); chk("R2 lane1", d, 8'hA5);
    busWr(24'hFFFF0A, 8'hFF); busRd(24'hFFFF0A, d); chk("R2 lane2 pad", d, 8'hFC);
    busWr(24'hFFFF0B, 8'hFF); busRd(24'hFFFF0B, d); chk("R2 lane3 enable", d, 8'h80);
    busWr(24'hFFFF80, 8'hFF); busRd(24'hFFFF80, d); chk("R6 global readback", d, 8'h01);
    // R3 unimplemented offsets and outside window
    busWr(24'hFFFF90, 8'hFF); busRd(24'hFFFF90, d); chk("R3 unimplemented offset", d, 8'h00);
    busRd(24'h12340A, d); chk("R3 outside window", d, 8'h00);
    busWr(24'hFFFF0B, 8'h00); busRd(24'hFFFF0B, d); chk("R2 enable clear", d, 8'h00);

    // Program entries 0, 5 (disabled), 7, 31
    busWr(24'hFFFF00, 8'h01); busWr(24'hFFFF01, 8'h23);
    busWr(24'hFFFF02, 8'h44); busWr(24'hFFFF03, 8'h80);
    busWr(24'hFFFF14, 8'h0A); busWr(24'hFFFF15, 8'hBC);
    busWr(24'hFFFF16, 8'hD8); busWr(24'hFFFF17, 8'h7F);
    busWr(24'hFFFF1C, 8'h05); busWr(24'hFFFF1D, 8'h00);
    busWr(24'hFFFF1E, 8'h00); busWr(24'hFFFF1F, 8'h80);
    busWr(24'hFFFF7C, 8'h0F); busWr(24'hFFFF7D, 8'hFF);
    busWr(24'hFFFF7E, 8'hFC); busWr(24'hFFFF7F, 8'h80);
    busRd(24'hFFFF17, d); chk("R2 enable pad bits", d, 8'h00);
    busRd(24'hFFFF7E, d); chk("R8 entry 31 readback", d, 8'hFC);

    for (int i = 0; i < NV; i++)
      probe($sformatf("R4 vector %0d", i), VEC[i][25:2], VEC[i][1], VEC[i][0]);

    // R5: strobe held for many clocks, one pulse only
    @(negedge clk);
    busAddr = 24'h012344; romSel = 1'b1; busStrobe = 1'b1;
    @(negedge clk); chk("R5 first edge pulse", {7'b0, irqReq}, 8'h01);
    repeat (4) begin
      @(negedge clk); chk("R5 no retrigger", {7'b0, irqReq}, 8'h00);
    end
    busStrobe = 1'b0; romSel = 1'b0;
    @(negedge clk);

    // R6 global enable cleared
    busWr(24'hFFFF80, 8'hFE);
    probe("R6 global off", 24'h012344, 1'b1, 1'b0);
    busWr(24'hFFFF80, 8'h01);
    probe("R6 global back on", 24'h012344, 1'b1, 1'b1);

    // R1 reset mid-run
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    busRd(24'hFFFF03, d); chk("R1 enable cleared by reset", d, 8'h00);
    busRd(24'hFFFF01, d); chk("R1 address cleared by reset", d, 8'h00);
    probe("R1 no request after reset", 24'h012344, 1'b1, 1'b0);

    summary();
  end
endmodule